// File: doc/BRIEF.md
# Quad Multiply Add/Subtract Summation Unit

This datapath block takes four operand pairs, forms four products of an m-bit and an n-bit operand, and combines them in two independent pair stages. Each pair stage either adds or subtracts its two products, under its own select input. The two pair results are then added into one output word. Operands and products are treated as two's complement or as unsigned numbers, as the mode input selects. Each step that makes a value wider extends it by sign or by zero to match.

There are three register stages: input, pipeline and output. Each one can be built in or bypassed through a parameter. The control inputs (mode and the two operation selects) and a valid flag travel through the same stages as the data, so each result carries the controls that were presented with its operands. Each operand's input register can take its value from the parallel operand port or from a shift chain instead. The shift chain lets operands be cascaded from one unit to the next. Every built-in stage uses one bit from a four-wide clock-enable pool and one bit from a four-wide active-low synchronous reset pool, each chosen by parameter. The whole block runs on one clock.

Top module: `quad_mac_sum`

## Requirements
- R1: Operand lane i is bits [i*m +: m] of `a_in` and bits [i*n +: n] of `b_in`. The first pair result is lane0 product plus lane1 product when `sub_sel0`=0, or lane0 product minus lane1 product when `sub_sel0`=1. The second pair works the same way with lanes 2 and 3 and `sub_sel1`.
- R2: `sum_out` is m+n+2 bits wide and equals the first pair result plus the second pair result, taken modulo 2^(m+n+2).
- R3: When `signed_mode`=1, operands, products and pair results are two's complement values and are sign-extended when they are widened. When `signed_mode`=0, they are unsigned values and are zero-extended. An unsigned pair result is kept modulo 2^(m+n+1) before the final sum, so an unsigned subtraction that goes below zero wraps.
- R4: Parameters `USE_IN_REG`, `USE_PIPE_REG` and `USE_OUT_REG` each build in or bypass one stage. Latency from the inputs to `sum_out` equals the number of stages built in. `out_valid` repeats `in_valid` with that same latency.
- R5: The values of `signed_mode`, `sub_sel0` and `sub_sel1` that are presented in a cycle govern the result of the operands presented in that same cycle, even when the controls change every cycle.
- R6: Setting bit i of `A_FROM_CHAIN` or `B_FROM_CHAIN` makes lane i's input register load from lane i-1's input register, or from `shin_a`/`shin_b` for lane 0. `shout_a`/`shout_b` present lane 3's input register.
- R7: A built-in stage keeps its data, controls and valid flag unchanged on every clock where its selected `ce_pool` bit is 0.
- R8: When a built-in stage's selected `rstn_pool` bit is 0 at a clock edge, that stage's data, controls and valid flag become zero. This takes priority over the clock enable and leaves every other stage unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all stages |
| ce_pool | input | 4 | Clock-enable sources; each stage uses one bit |
| rstn_pool | input | 4 | Active-low synchronous reset sources; each stage uses one bit |
| in_valid | input | 1 | Marks the operands of this cycle as a real item |
| signed_mode | input | 1 | 1 = two's complement arithmetic, 0 = unsigned |
| sub_sel0 | input | 1 | 1 = subtract lane1 product from lane0 product |
| sub_sel1 | input | 1 | 1 = subtract lane3 product from lane2 product |
| a_in | input | 4*A_W | Parallel A operands, lane i at [i*A_W +: A_W] |
| b_in | input | 4*B_W | Parallel B operands, lane i at [i*B_W +: B_W] |
| shin_a | input | A_W | A shift-chain input from the upstream unit |
| shin_b | input | B_W | B shift-chain input from the upstream unit |
| shout_a | output | A_W | A shift-chain output (lane 3 input register) |
| shout_b | output | B_W | B shift-chain output (lane 3 input register) |
| out_valid | output | 1 | Valid flag aligned with sum_out |
| sum_out | output | A_W+B_W+2 | Sum of the two pair results |

## Verification
The hardest situation to reach is one stage standing still while the stages upstream keep moving. In that case the output register must hold an old result while the pipeline register takes newer operands, and must then release exactly that newer item when its enable returns. The bench creates this by using separate pool bits for each stage: it drops only the output stage's enable just after a known result arrives, and presents a new operand set while the enable is low. It then resets only the output stage and shows that the input stage still holds its data, using the shift-out port. A second instance, whose input registers are all chained and whose other stages are bypassed, is filled through the shift-in ports. That instance shows the lane order of the chain and a latency of one cycle.

// File: rtl/qmas_pkg.sv
// Package: shared constants and the control bundle type for the quad
// multiply add/subtract summation unit.
// Assumes: exactly four lanes and four-entry enable/reset pools.
package qmas_pkg;
    localparam int LANES = 4;
    localparam int POOL  = 4;

    // Control bundle that travels alongside the data through each stage.
    typedef struct packed {
        logic sgn;   // two's complement when set
        logic sub0;  // first pair subtracts when set
        logic sub1;  // second pair subtracts when set
        logic vld;   // item valid
    } qmas_ctl_t;

    localparam int CTL_W = $bits(qmas_ctl_t);
endpackage

// File: rtl/qmas_stage.sv
// Module: one optional register stage of the datapath.
// When EN is nonzero it builds a register that uses clock enable bit CE_SEL
// and active-low synchronous reset bit RST_SEL, each taken from the pools.
// Reset wins over enable. When EN is zero, q follows d combinationally.
// Assumes: CE_SEL and RST_SEL lie in 0..POOL-1.
module qmas_stage
    import qmas_pkg::*;
#(
    parameter int W       = 8,
    parameter int EN      = 1,
    parameter int CE_SEL  = 0,
    parameter int RST_SEL = 0
) (
    input  logic            clk,
    input  logic [POOL-1:0] ce_pool,
    input  logic [POOL-1:0] rstn_pool,
    input  logic [W-1:0]    d,
    output logic [W-1:0]    q
);
    generate
        if (EN != 0) begin : g_reg
            logic [W-1:0] r;
            // Register with selected reset (priority) and selected enable.
            always_ff @(posedge clk) begin
                if (!rstn_pool[RST_SEL]) begin
                    r <= '0;
                end else if (ce_pool[CE_SEL]) begin
                    r <= d;
                end
            end
            assign q = r;
        end else begin : g_byp
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/qmas_in_bank.sv
// Module: input register bank for one operand kind (A or B), all lanes.
// Each lane loads either its parallel port slice or, when its FROM_CHAIN
// bit is set, the previous lane's register (lane 0 takes shin).
// shout presents the last lane. Assumes LANES lanes packed lane 0 lowest.
module qmas_in_bank
    import qmas_pkg::*;
#(
    parameter int             W          = 8,
    parameter int             EN         = 1,
    parameter logic [LANES-1:0] FROM_CHAIN = '0,
    parameter int             CE_SEL     = 0,
    parameter int             RST_SEL    = 0
) (
    input  logic               clk,
    input  logic [POOL-1:0]    ce_pool,
    input  logic [POOL-1:0]    rstn_pool,
    input  logic [LANES*W-1:0] par_in,
    input  logic [W-1:0]       shin,
    output logic [LANES*W-1:0] ops,
    output logic [W-1:0]       shout
);
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            logic [W-1:0] src;
            logic [W-1:0] q;
            if (FROM_CHAIN[i] && i == 0) begin : g_head
                assign src = shin;
            end else if (FROM_CHAIN[i]) begin : g_link
                assign src = g_lane[i-1].q;
            end else begin : g_par
                assign src = par_in[i*W +: W];
            end

            qmas_stage #(
                .W(W), .EN(EN), .CE_SEL(CE_SEL), .RST_SEL(RST_SEL)
            ) u_reg (
                .clk(clk), .ce_pool(ce_pool), .rstn_pool(rstn_pool),
                .d(src), .q(q)
            );
            assign ops[i*W +: W] = q;
        end
    endgenerate

    assign shout = g_lane[LANES-1].q;
endmodule

// File: rtl/qmas_mult.sv
// Module: one A_W by B_W multiplier with signed/unsigned mode.
// Both operands are extended (sign or zero) to the product width and
// multiplied; the low A_W+B_W bits are exact for either interpretation.
module qmas_mult #(
    parameter int A_W = 8,
    parameter int B_W = 8
) (
    input  logic [A_W-1:0]     a,
    input  logic [B_W-1:0]     b,
    input  logic               sgn,
    output logic [A_W+B_W-1:0] p
);
    localparam int PW = A_W + B_W;

    logic [PW-1:0] a_x;
    logic [PW-1:0] b_x;

    // Widen operands by sign or zero according to mode.
    always_comb begin
        a_x = {{B_W{sgn & a[A_W-1]}}, a};
        b_x = {{A_W{sgn & b[B_W-1]}}, b};
    end

    // Truncated product of the widened operands.
    always_comb begin
        p = a_x * b_x;
    end
endmodule

// File: rtl/qmas_addsub.sv
// Module: widening adder/subtractor. Both W-bit inputs are extended by one
// bit (sign when sgn is set, zero otherwise), then x+y or x-y is formed
// modulo 2^(W+1). Used for the pair stages and, with sub tied low, for
// the final summation.
module qmas_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sgn,
    input  logic         sub,
    output logic [W:0]   r
);
    logic [W:0] x_x;
    logic [W:0] y_x;

    // One-bit widening of each operand.
    always_comb begin
        x_x = {sgn & x[W-1], x};
        y_x = {sgn & y[W-1], y};
    end

    // Add or subtract at the widened width.
    always_comb begin
        r = sub ? (x_x - y_x) : (x_x + y_x);
    end
endmodule

// File: rtl/quad_mac_sum.sv
// Module: quad multiply add/subtract summation unit (top).
// Datapath: input stage -> four multipliers -> pipeline stage ->
// two pair add/sub -> final sum -> output stage. Controls and valid ride
// in a bundle through input and pipeline stages; valid also through the
// output stage. Assumes one clock; each stage's enable and reset come
// from pool bits chosen by parameter.
module quad_mac_sum
    import qmas_pkg::*;
#(
    parameter int               A_W          = 8,
    parameter int               B_W          = 8,
    parameter int               USE_IN_REG   = 1,
    parameter int               USE_PIPE_REG = 1,
    parameter int               USE_OUT_REG  = 1,
    parameter logic [3:0]       A_FROM_CHAIN = 4'b0000,
    parameter logic [3:0]       B_FROM_CHAIN = 4'b0000,
    parameter int               IN_CE_SEL    = 0,
    parameter int               IN_RST_SEL   = 0,
    parameter int               PIPE_CE_SEL  = 0,
    parameter int               PIPE_RST_SEL = 0,
    parameter int               OUT_CE_SEL   = 0,
    parameter int               OUT_RST_SEL  = 0
) (
    input  logic                 clk,
    input  logic [3:0]           ce_pool,
    input  logic [3:0]           rstn_pool,
    input  logic                 in_valid,
    input  logic                 signed_mode,
    input  logic                 sub_sel0,
    input  logic                 sub_sel1,
    input  logic [4*A_W-1:0]     a_in,
    input  logic [4*B_W-1:0]     b_in,
    input  logic [A_W-1:0]       shin_a,
    input  logic [B_W-1:0]       shin_b,
    output logic [A_W-1:0]       shout_a,
    output logic [B_W-1:0]       shout_b,
    output logic                 out_valid,
    output logic [A_W+B_W+1:0]   sum_out
);
    localparam int PW = A_W + B_W;   // product width
    localparam int RW = PW + 1;      // pair result width
    localparam int SW = PW + 2;      // final sum width

    qmas_ctl_t ctl_in, ctl_s1, ctl_s2;
    logic [LANES*A_W-1:0] a_s1;
    logic [LANES*B_W-1:0] b_s1;
    logic [LANES*PW-1:0]  prod_s1, prod_s2;
    logic [RW-1:0]        pair0, pair1;
    logic [SW-1:0]        sum_c;
    logic [SW:0]          out_d, out_q;

    // Bundle the control inputs with the valid flag.
    always_comb begin
        ctl_in = '{sgn: signed_mode, sub0: sub_sel0, sub1: sub_sel1, vld: in_valid};
    end

    // Input stage: operand banks (with optional chaining) and control.
    qmas_in_bank #(
        .W(A_W), .EN(USE_IN_REG), .FROM_CHAIN(A_FROM_CHAIN),
        .CE_SEL(IN_CE_SEL), .RST_SEL(IN_RST_SEL)
    ) u_bank_a (
        .clk(clk), .ce_pool(ce_pool), .rstn_pool(rstn_pool),
        .par_in(a_in), .shin(shin_a), .ops(a_s1), .shout(shout_a)
    );

    qmas_in_bank #(
        .W(B_W), .EN(USE_IN_REG), .FROM_CHAIN(B_FROM_CHAIN),
        .CE_SEL(IN_CE_SEL), .RST_SEL(IN_RST_SEL)
    ) u_bank_b (
        .clk(clk), .ce_pool(ce_pool), .rstn_pool(rstn_pool),
        .par_in(b_in), .shin(shin_b), .ops(b_s1), .shout(shout_b)
    );

    qmas_stage #(
        .W(CTL_W), .EN(USE_IN_REG), .CE_SEL(IN_CE_SEL), .RST_SEL(IN_RST_SEL)
    ) u_ctl_in (
        .clk(clk), .ce_pool(ce_pool), .rstn_pool(rstn_pool),
        .d(ctl_in), .q(ctl_s1)
    );

    // Four multipliers, mode taken from the input-stage control.
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_mul
            qmas_mult #(.A_W(A_W), .B_W(B_W)) u_mul (
                .a(a_s1[i*A_W +: A_W]),
                .b(b_s1[i*B_W +: B_W]),
                .sgn(ctl_s1.sgn),
                .p(prod_s1[i*PW +: PW])
            );
        end
    endgenerate

    // Pipeline stage: products and control.
    qmas_stage #(
        .W(LANES*PW), .EN(USE_PIPE_REG), .CE_SEL(PIPE_CE_SEL), .RST_SEL(PIPE_RST_SEL)
    ) u_pipe_data (
        .clk(clk), .ce_pool(ce_pool), .rstn_pool(rstn_pool),
        .d(prod_s1), .q(prod_s2)
    );

    qmas_stage #(
        .W(CTL_W), .EN(USE_PIPE_REG), .CE_SEL(PIPE_CE_SEL), .RST_SEL(PIPE_RST_SEL)
    ) u_pipe_ctl (
        .clk(clk), .ce_pool(ce_pool), .rstn_pool(rstn_pool),
        .d(ctl_s1), .q(ctl_s2)
    );

    // Pair stages, each with its own operation select.
    qmas_addsub #(.W(PW)) u_pair0 (
        .x(prod_s2[0*PW +: PW]), .y(prod_s2[1*PW +: PW]),
        .sgn(ctl_s2.sgn), .sub(ctl_s2.sub0), .r(pair0)
    );

    qmas_addsub #(.W(PW)) u_pair1 (
        .x(prod_s2[2*PW +: PW]), .y(prod_s2[3*PW +: PW]),
        .sgn(ctl_s2.sgn), .sub(ctl_s2.sub1), .r(pair1)
    );

    // Final summation of the two pair results.
    qmas_addsub #(.W(RW)) u_sum (
        .x(pair0), .y(pair1), .sgn(ctl_s2.sgn), .sub(1'b0), .r(sum_c)
    );

    // Output stage: sum and valid flag together.
    always_comb begin
        out_d = {ctl_s2.vld, sum_c};
    end

    qmas_stage #(
        .W(SW+1), .EN(USE_OUT_REG), .CE_SEL(OUT_CE_SEL), .RST_SEL(OUT_RST_SEL)
    ) u_out (
        .clk(clk), .ce_pool(ce_pool), .rstn_pool(rstn_pool),
        .d(out_d), .q(out_q)
    );

    assign out_valid = out_q[SW];
    assign sum_out   = out_q[SW-1:0];
endmodule

// File: rtl/quad_mac_sum_chk.sv
// Checker: port-level properties of quad_mac_sum, bound to every instance.
// Global reset for disabling is the whole reset pool being low.
module quad_mac_sum_chk #(
    parameter int A_W          = 8,
    parameter int B_W          = 8,
    parameter int USE_IN_REG   = 1,
    parameter int USE_PIPE_REG = 1,
    parameter int USE_OUT_REG  = 1,
    parameter int IN_CE_SEL    = 0,
    parameter int IN_RST_SEL   = 0,
    parameter int OUT_CE_SEL   = 0,
    parameter int OUT_RST_SEL  = 0
) (
    input logic               clk,
    input logic [3:0]         ce_pool,
    input logic [3:0]         rstn_pool,
    input logic               in_valid,
    input logic [A_W-1:0]     shout_a,
    input logic [B_W-1:0]     shout_b,
    input logic               out_valid,
    input logic [A_W+B_W+1:0] sum_out
);
    localparam bit ALL_BYPASS = (USE_IN_REG == 0) && (USE_PIPE_REG == 0) && (USE_OUT_REG == 0);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rstn_pool == 4'b0000)
        (USE_OUT_REG != 0 && !ce_pool[OUT_CE_SEL] && rstn_pool[OUT_RST_SEL])
        |=> ($stable(sum_out) && $stable(out_valid)));

    // R8
    out_clear_chk: assert property (@(posedge clk) disable iff (rstn_pool == 4'b0000)
        (USE_OUT_REG != 0 && !rstn_pool[OUT_RST_SEL])
        |=> (sum_out == '0 && !out_valid));

    // R7
    in_hold_chk: assert property (@(posedge clk) disable iff (rstn_pool == 4'b0000)
        (USE_IN_REG != 0 && !ce_pool[IN_CE_SEL] && rstn_pool[IN_RST_SEL])
        |=> ($stable(shout_a) && $stable(shout_b)));

    // R8
    in_clear_chk: assert property (@(posedge clk) disable iff (rstn_pool == 4'b0000)
        (USE_IN_REG != 0 && !rstn_pool[IN_RST_SEL])
        |=> (shout_a == '0 && shout_b == '0));

    // R4
    no_latency_chk: assert property (@(posedge clk) disable iff (rstn_pool == 4'b0000)
        ALL_BYPASS |-> (out_valid == in_valid));
endmodule

bind quad_mac_sum quad_mac_sum_chk #(
    .A_W(A_W), .B_W(B_W),
    .USE_IN_REG(USE_IN_REG), .USE_PIPE_REG(USE_PIPE_REG), .USE_OUT_REG(USE_OUT_REG),
    .IN_CE_SEL(IN_CE_SEL), .IN_RST_SEL(IN_RST_SEL),
    .OUT_CE_SEL(OUT_CE_SEL), .OUT_RST_SEL(OUT_RST_SEL)
) u_chk (.*);

// File: tb/quad_mac_sum_tb.sv
// Bench: scoreboard for the fully registered instance plus directed
// checks on stage hold/reset and on a chained, single-stage instance.
module quad_mac_sum_tb;
    localparam int AW = 8;
    localparam int BW = 8;
    localparam int SW = AW + BW + 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [3:0]      ce_pool, rstn_pool;
    logic            in_valid, sgn, s0, s1;
    logic [4*AW-1:0] a_in;
    logic [4*BW-1:0] b_in;
    logic [AW-1:0]   shout_a;
    logic [BW-1:0]   shout_b;
    logic            out_valid;
    logic [SW-1:0]   sum_out;

    logic            in_valid_c, sgn_c, s0_c, s1_c;
    logic [AW-1:0]   shin_ac, shout_ac;
    logic [BW-1:0]   shin_bc, shout_bc;
    logic            out_valid_c;
    logic [SW-1:0]   sum_out_c;

    int total = 0;
    int bad   = 0;
    bit mon_on = 1'b0;
    logic [SW-1:0] exp_q[$];

    quad_mac_sum #(
        .A_W(AW), .B_W(BW),
        .IN_CE_SEL(1), .IN_RST_SEL(1), .PIPE_CE_SEL(2), .PIPE_RST_SEL(2),
        .OUT_CE_SEL(3), .OUT_RST_SEL(3)
    ) u_dut (
        .clk(clk), .ce_pool(ce_pool), .rstn_pool(rstn_pool), .in_valid(in_valid),
        .signed_mode(sgn), .sub_sel0(s0), .sub_sel1(s1), .a_in(a_in), .b_in(b_in),
        .shin_a('0), .shin_b('0), .shout_a(shout_a), .shout_b(shout_b),
        .out_valid(out_valid), .sum_out(sum_out)
    );

    quad_mac_sum #(
        .A_W(AW), .B_W(BW), .USE_IN_REG(1), .USE_PIPE_REG(0), .USE_OUT_REG(0),
        .A_FROM_CHAIN(4'b1111), .B_FROM_CHAIN(4'b1111)
    ) u_chain (
        .clk(clk), .ce_pool(ce_pool), .rstn_pool(rstn_pool), .in_valid(in_valid_c),
        .signed_mode(sgn_c), .sub_sel0(s0_c), .sub_sel1(s1_c), .a_in('0), .b_in('0),
        .shin_a(shin_ac), .shin_b(shin_bc), .shout_a(shout_ac), .shout_b(shout_bc),
        .out_valid(out_valid_c), .sum_out(sum_out_c)
    );

    // Reference model built from R1, R2, R3.
    function automatic logic [SW-1:0] model(input logic [4*AW-1:0] a, input logic [4*BW-1:0] b,
                                            input logic sg, input logic m0, input logic m1);
        longint p[4];
        longint r0, r1, t;
        for (int i = 0; i < 4; i++) begin
            longint va, vb;
            va = sg ? longint'($signed(a[i*AW +: AW])) : longint'(a[i*AW +: AW]);
            vb = sg ? longint'($signed(b[i*BW +: BW])) : longint'(b[i*BW +: BW]);
            p[i] = va * vb;
        end
        r0 = m0 ? p[0] - p[1] : p[0] + p[1];
        r1 = m1 ? p[2] - p[3] : p[2] + p[3];
        if (!sg) begin
            r0 = r0 & ((longint'(1) << (SW-1)) - 1);
            r1 = r1 & ((longint'(1) << (SW-1)) - 1);
        end
        t = r0 + r1;
        return t[SW-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Driver: presents one item and queues its expected sum.
    task automatic send(input logic [4*AW-1:0] a, input logic [4*BW-1:0] b,
                        input logic sg, input logic m0, input logic m1);
        a_in = a; b_in = b; sgn = sg; s0 = m0; s1 = m1; in_valid = 1'b1;
        if (mon_on) exp_q.push_back(model(a, b, sg, m0, m1));
        @(negedge clk);
    endtask

    // Monitor: pops and compares each valid result.
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected out_valid", 1, 0);
                end else begin
                    logic [SW-1:0] e;
                    e = exp_q.pop_front();
                    check(sum_out == e, "R1/R2/R3/R5 sum", sum_out, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=1 exp=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [4*AW-1:0] va, wa;
        logic [4*BW-1:0] vb, wb;
        logic [SW-1:0]   ve, we;
        logic [AW-1:0]   xa[4];
        logic [BW-1:0]   yb[4];
        int n;

        rstn_pool = 4'b0000; ce_pool = 4'b1111;
        in_valid = 0; sgn = 0; s0 = 0; s1 = 0; a_in = '0; b_in = '0;
        in_valid_c = 0; sgn_c = 0; s0_c = 0; s1_c = 0; shin_ac = '0; shin_bc = '0;
        repeat (3) @(negedge clk);
        // R8 reset state
        check(sum_out == '0, "R8 reset sum", sum_out, 0);
        check(!out_valid, "R8 reset valid", out_valid, 0);
        check(shout_a == '0 && shout_b == '0, "R8 reset shift-out", shout_a, 0);
        check(sum_out_c == '0 && !out_valid_c, "R8 reset chain unit", sum_out_c, 0);
        rstn_pool = 4'b1111;
        @(negedge clk);

        // Scoreboard stream: corner values, then random with changing controls.
        mon_on = 1'b1;
        send('0, '0, 0, 0, 0);
        send({4{8'hFF}}, {4{8'hFF}}, 0, 0, 0);                    // R3 unsigned maximum
        send({8'h00, 8'h00, 8'h01, 8'h00}, {8'h00, 8'h00, 8'h01, 8'h00}, 0, 1, 0); // R3 unsigned wrap
        send({4{8'h80}}, {4{8'h80}}, 1, 0, 0);                    // R3 signed extremes
        send({8'h80, 8'h7F, 8'h80, 8'h7F}, {8'h7F, 8'h80, 8'h7F, 8'h80}, 1, 1, 1); // R1 subtract
        send({8'h02, 8'h03, 8'h04, 8'h05}, {8'h06, 8'h07, 8'h08, 8'h09}, 0, 1, 1);
        for (int k = 0; k < 40; k++) begin
            send({$urandom, $urandom}, {$urandom, $urandom},
                 1'($urandom), 1'($urandom), 1'($urandom));        // R5 controls vary per item
        end
        in_valid = 0;
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R4 all items returned", exp_q.size(), 0);
        mon_on = 1'b0;

        // R4 latency of three with all stages built in.
        va = {8'h11, 8'hF3, 8'h25, 8'h97}; vb = {8'h42, 8'h08, 8'hC1, 8'h5A};
        ve = model(va, vb, 1, 1, 0);
        send(va, vb, 1, 1, 0);
        in_valid = 0;
        n = 1;
        while (!out_valid && n < 10) begin
            @(negedge clk);
            n++;
        end
        check(n == 3, "R4 latency", n, 3);
        check(sum_out == ve, "R4 latency result", sum_out, ve);

        // R7 output stage holds while upstream moves on.
        ce_pool[3] = 1'b0;
        wa = {8'h7E, 8'h01, 8'hC8, 8'h33}; wb = {8'h05, 8'hFF, 8'h19, 8'h6D};
        we = model(wa, wb, 0, 0, 1);
        a_in = wa; b_in = wb; sgn = 0; s0 = 0; s1 = 1; in_valid = 1;
        repeat (4) @(negedge clk);
        check(sum_out == ve, "R7 output hold sum", sum_out, ve);
        check(out_valid == 1'b1, "R7 output hold valid", out_valid, 1);
        ce_pool[3] = 1'b1; in_valid = 0;
        @(negedge clk);
        check(sum_out == we, "R7 release newer item", sum_out, we);

        // R8 output-only reset, priority over a low enable, input stage untouched.
        rstn_pool[3] = 1'b0; ce_pool[3] = 1'b0;
        @(negedge clk);
        check(sum_out == '0 && !out_valid, "R8 output stage cleared", sum_out, 0);
        check(shout_a == wa[31:24], "R8 input stage unaffected A", shout_a, wa[31:24]);
        check(shout_b == wb[31:24], "R8 input stage unaffected B", shout_b, wb[31:24]);
        rstn_pool[3] = 1'b1; ce_pool[3] = 1'b1;
        rstn_pool[1] = 1'b0;
        @(negedge clk);
        check(shout_a == '0 && shout_b == '0, "R8 input stage cleared", shout_a, 0);
        rstn_pool[1] = 1'b1;

        // R6 chained instance: fill four lanes through shift-in.
        xa = '{8'h03, 8'hFE, 8'h10, 8'h81};
        yb = '{8'h05, 8'h07, 8'hF0, 8'h02};
        sgn_c = 1; s0_c = 1; s1_c = 0;
        for (int k = 0; k < 4; k++) begin
            shin_ac = xa[k]; shin_bc = yb[k]; in_valid_c = (k == 3);
            @(negedge clk);
        end
        in_valid_c = 0;
        ve = model({xa[0], xa[1], xa[2], xa[3]}, {yb[0], yb[1], yb[2], yb[3]}, 1, 1, 0);
        check(sum_out_c == ve, "R6 chained lane order", sum_out_c, ve);
        check(out_valid_c == 1'b1, "R4 single-stage latency", out_valid_c, 1);
        check(shout_ac == xa[0], "R6 shift-out A", shout_ac, xa[0]);
        check(shout_bc == yb[0], "R6 shift-out B", shout_bc, yb[0]);

        // R7 chain frozen while its enable is low.
        ce_pool[0] = 1'b0; shin_ac = 8'h55; shin_bc = 8'h66;
        repeat (2) @(negedge clk);
        check(shout_ac == xa[0], "R7 chain hold", shout_ac, xa[0]);
        check(out_valid_c == 1'b1, "R7 chain valid hold", out_valid_c, 1);
        ce_pool[0] = 1'b1;
        @(negedge clk);
        check(shout_ac == xa[1], "R6 chain advances one lane", shout_ac, xa[1]);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule